// File: doc/BRIEF.md
# Checked data memory access unit

This block connects a 32-bit processor core to a small byte-addressed local RAM held inside the block. The core issues single-cycle requests for byte, halfword or word loads and stores. The block checks every request before it touches the RAM. An address at or beyond the configured size is rejected as out of range. A word or halfword access that is not naturally aligned is rejected as misaligned. A rejected store leaves memory untouched, and a rejected load returns zero. In both cases a two-bit fault code comes back alongside the response.

The byte order is fixed at build time. With big-endian order, the lowest address of a multi-byte item holds its most significant byte. With little-endian order, the lowest address holds its least significant byte. A second read-only port serves instruction fetch. It always returns the full aligned word that contains the given program counter, assembled in the same byte order. It reports only out-of-range faults.

Responses are registered: a request presented at a clock edge is answered in the following cycle on both ports. The RAM is split into four byte-wide lanes, so that block RAM can be inferred with a write enable per byte.

Top module: `chk_mem_unit`

## Requirements
- R1: While reset is high and in the cycle after it, `rsp_valid`, `rsp_fault`, `rsp_rdata`, `if_valid`, `if_fault` and `if_rdata` are all zero.
- R2: A request accepted with `req_valid` high is answered exactly one cycle later with `rsp_valid` high. The fault code is 00 for no fault, 01 for out of range and 10 for misaligned, and it is valid in that same cycle. Size codes are 00 byte, 01 halfword, 10 word and 11 treated as word.
- R3: Any data access with address >= MEM_BYTES gets fault 01. A store with that fault changes no byte, and a load with that fault returns zero.
- R4: A word access with either of address bits 1:0 set gets fault 10. It writes nothing and reads back zero.
- R5: A halfword access with address bit 0 set gets fault 10. A byte access never gets fault 10.
- R6: An access that is both out of range and misaligned reports 01.
- R7: With BIG_END=1, the byte at the lowest address of a halfword or word is its most significant byte, both on store and on load.
- R8: With BIG_END=0, the byte at the lowest address of a halfword or word is its least significant byte, both on store and on load.
- R9: Byte and halfword loads return the value zero-extended to 32 bits. Byte and halfword stores write only bits 7:0 or 15:0 of `req_wdata`, and leave the neighbouring bytes intact.
- R10: A fetch with `if_req` high returns, one cycle later with `if_valid` high, the word at `if_addr` with bits 1:0 cleared, in the configured byte order. It never reports a misalignment. If `if_addr >= MEM_BYTES`, `if_fault` is 1 and `if_rdata` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Data request strobe |
| req_we | input | 1 | 1 for store, 0 for load |
| req_size | input | 2 | 00 byte, 01 halfword, 10/11 word |
| req_addr | input | 32 | Byte address of the access |
| req_wdata | input | 32 | Store data, low-aligned |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_fault | output | 2 | 00 none, 01 range, 10 alignment |
| rsp_rdata | output | 32 | Zero-extended load data, zero on fault or store |
| if_req | input | 1 | Fetch request strobe |
| if_addr | input | 32 | Program counter; bits 1:0 ignored for data |
| if_valid | output | 1 | Fetch response strobe |
| if_fault | output | 1 | Fetch address out of range |
| if_rdata | output | 32 | Fetched word, zero on fault |

## Verification
On every cycle, the assertions check the following:
- the one-cycle response timing;
- that out-of-range requests report the range code, whatever their alignment;
- that faulted responses carry zero data;
- that a misaligned word store raises no byte write enable;
- that byte accesses and in-range fetches never report misalignment.

Some behaviour only the bench's scenarios can show, because it depends on the memory's history. This covers the exact byte placement in both orders, zero extension, untouched neighbour bytes, and the fact that faulted stores leave memory unchanged. The bench tracks these with a byte model per byte order and reads the contents back through both ports.

// File: rtl/chk_mem_pkg.sv
package chk_mem_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10,
    SZ_WRSV = 2'b11
  } acc_size_e;

  typedef enum logic [1:0] {
    FLT_NONE  = 2'b00,
    FLT_RANGE = 2'b01,
    FLT_ALIGN = 2'b10
  } fault_e;

  localparam int LANES = 4;

  // number of bytes moved by one access of the given size
  function automatic logic [2:0] size_bytes(input acc_size_e sz);
    case (sz)
      SZ_BYTE: size_bytes = 3'd1;
      SZ_HALF: size_bytes = 3'd2;
      default: size_bytes = 3'd4;
    endcase
  endfunction

endpackage

// File: rtl/chk_mem_check.sv
module chk_mem_check
  import chk_mem_pkg::*;
#(
  parameter int MEM_BYTES = 4096
) (
  input  logic [31:0] addr,
  input  acc_size_e   size,
  output fault_e      fault
);
  localparam logic [32:0] LIMIT = 33'(MEM_BYTES);

  logic out_of_range;
  logic misaligned;

  always_comb begin
    out_of_range = ({1'b0, addr} >= LIMIT);
    case (size)
      SZ_BYTE: misaligned = 1'b0;
      SZ_HALF: misaligned = addr[0];
      default: misaligned = |addr[1:0];
    endcase
    // range is decided first; alignment only matters for in-range addresses
    if (out_of_range)    fault = FLT_RANGE;
    else if (misaligned) fault = FLT_ALIGN;
    else                 fault = FLT_NONE;
  end

endmodule

// File: rtl/chk_mem_lane_pack.sv
module chk_mem_lane_pack
  import chk_mem_pkg::*;
#(
  parameter bit BIG_END = 1'b1
) (
  input  logic        en,
  input  logic [1:0]  off,
  input  acc_size_e   size,
  input  logic [31:0] wdata,
  output logic [3:0]  lane_we,
  output logic [31:0] lane_wd
);
  int n;
  int rel;
  int idx;

  always_comb begin
    lane_we = '0;
    lane_wd = '0;
    n   = int'(size_bytes(size));
    rel = 0;
    idx = 0;
    for (int k = 0; k < LANES; k++) begin
      rel = k - int'(off);
      if (rel >= 0 && rel < n) begin
        // position of this lane's byte inside the low-aligned store value
        idx = BIG_END ? (n - 1 - rel) : rel;
        lane_we[k]        = en;
        lane_wd[8*k +: 8] = wdata[8*idx +: 8];
      end
    end
  end

endmodule

// File: rtl/chk_mem_lane_unpack.sv
module chk_mem_lane_unpack
  import chk_mem_pkg::*;
#(
  parameter bit BIG_END = 1'b1
) (
  input  logic [1:0]  off,
  input  acc_size_e   size,
  input  logic [31:0] lanes,
  output logic [31:0] value
);
  int n;
  int lane;

  always_comb begin
    value = '0;
    n     = int'(size_bytes(size));
    lane  = 0;
    for (int j = 0; j < LANES; j++) begin
      if (j < n) begin
        lane = BIG_END ? (int'(off) + n - 1 - j) : (int'(off) + j);
        value[8*j +: 8] = lanes[8*(lane & 3) +: 8];
      end
    end
  end

endmodule

// File: rtl/chk_mem_bank.sv
module chk_mem_bank
  import chk_mem_pkg::*;
#(
  parameter int DEPTH = 1024,
  parameter int IW    = 10
) (
  input  logic          clk,
  input  logic [3:0]    a_we,
  input  logic [IW-1:0] a_idx,
  input  logic [31:0]   a_wd,
  output logic [31:0]   a_rd,
  input  logic [IW-1:0] b_idx,
  output logic [31:0]   b_rd
);

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic [7:0] ram [DEPTH];
    logic [7:0] rd_a_q;
    logic [7:0] rd_b_q;

    // port A: read-first read/write, port B: read only
    always_ff @(posedge clk) begin
      if (a_we[k]) ram[a_idx] <= a_wd[8*k +: 8];
      rd_a_q <= ram[a_idx];
    end

    always_ff @(posedge clk) begin
      rd_b_q <= ram[b_idx];
    end

    assign a_rd[8*k +: 8] = rd_a_q;
    assign b_rd[8*k +: 8] = rd_b_q;
  end

endmodule

// File: rtl/chk_mem_unit.sv
module chk_mem_unit
  import chk_mem_pkg::*;
#(
  parameter int MEM_BYTES = 4096,
  parameter bit BIG_END   = 1'b1
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        req_valid,
  input  logic        req_we,
  input  logic [1:0]  req_size,
  input  logic [31:0] req_addr,
  input  logic [31:0] req_wdata,
  output logic        rsp_valid,
  output logic [1:0]  rsp_fault,
  output logic [31:0] rsp_rdata,
  input  logic        if_req,
  input  logic [31:0] if_addr,
  output logic        if_valid,
  output logic        if_fault,
  output logic [31:0] if_rdata
);
  localparam int          DEPTH = MEM_BYTES / 4;
  localparam int          IW    = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [32:0] LIMIT = 33'(MEM_BYTES);

  acc_size_e   size_in;
  fault_e      chk_fault;
  logic        acc_ok;
  logic [3:0]  lane_we;
  logic [31:0] lane_wd;
  logic [31:0] a_rd;
  logic [31:0] b_rd;
  logic [31:0] ld_value;
  logic [31:0] fetch_word;
  logic        f_range;

  logic        rsp_valid_q;
  fault_e      fault_q;
  logic        rd_use_q;
  logic [1:0]  off_q;
  acc_size_e   size_q;
  logic        if_valid_q;
  logic        if_fault_q;

  assign size_in = acc_size_e'(req_size);
  assign acc_ok  = req_valid && (chk_fault == FLT_NONE);
  assign f_range = ({1'b0, if_addr} >= LIMIT);

  chk_mem_check #(.MEM_BYTES(MEM_BYTES)) u_check (
    .addr  (req_addr),
    .size  (size_in),
    .fault (chk_fault)
  );

  chk_mem_lane_pack #(.BIG_END(BIG_END)) u_pack (
    .en      (acc_ok && req_we),
    .off     (req_addr[1:0]),
    .size    (size_in),
    .wdata   (req_wdata),
    .lane_we (lane_we),
    .lane_wd (lane_wd)
  );

  chk_mem_bank #(.DEPTH(DEPTH), .IW(IW)) u_bank (
    .clk   (clk),
    .a_we  (lane_we),
    .a_idx (req_addr[IW+1:2]),
    .a_wd  (lane_wd),
    .a_rd  (a_rd),
    .b_idx (if_addr[IW+1:2]),
    .b_rd  (b_rd)
  );

  chk_mem_lane_unpack #(.BIG_END(BIG_END)) u_load (
    .off   (off_q),
    .size  (size_q),
    .lanes (a_rd),
    .value (ld_value)
  );

  chk_mem_lane_unpack #(.BIG_END(BIG_END)) u_fetch (
    .off   (2'b00),
    .size  (SZ_WORD),
    .lanes (b_rd),
    .value (fetch_word)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid_q <= 1'b0;
      fault_q     <= FLT_NONE;
      rd_use_q    <= 1'b0;
      off_q       <= 2'b00;
      size_q      <= SZ_BYTE;
    end else begin
      rsp_valid_q <= req_valid;
      fault_q     <= req_valid ? chk_fault : FLT_NONE;
      rd_use_q    <= acc_ok && !req_we;
      off_q       <= req_addr[1:0];
      size_q      <= size_in;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      if_valid_q <= 1'b0;
      if_fault_q <= 1'b0;
    end else begin
      if_valid_q <= if_req;
      if_fault_q <= if_req && f_range;
    end
  end

  assign rsp_valid = rsp_valid_q;
  assign rsp_fault = fault_q;
  assign rsp_rdata = rd_use_q ? ld_value : 32'h0;
  assign if_valid  = if_valid_q;
  assign if_fault  = if_fault_q;
  assign if_rdata  = (if_valid_q && !if_fault_q) ? fetch_word : 32'h0;

  AST_RSP_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid); // R2
  AST_RANGE_WINS: assert property (@(posedge clk) disable iff (rst)
    (req_valid && ({1'b0, req_addr} >= LIMIT)) |=> (rsp_fault == FLT_RANGE)); // R6
  AST_FAULT_ZERO_DATA: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_fault != 2'b00) |-> (rsp_rdata == 32'h0)); // R3
  AST_NO_MISALIGNED_WRITE: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_we && req_size[1] && (req_addr[1:0] != 2'b00)) |-> (lane_we == 4'b0000)); // R4
  AST_BYTE_NEVER_ALIGN: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_size == 2'b00) |=> (rsp_fault != FLT_ALIGN)); // R5
  AST_FETCH_NO_ALIGN: assert property (@(posedge clk) disable iff (rst)
    (if_req && ({1'b0, if_addr} < LIMIT)) |=> (if_valid && !if_fault)); // R10

endmodule

// File: tb/chk_mem_unit_tb.sv
module chk_mem_unit_tb;
  localparam int CLK_P = 10;
  localparam int MEM_B = 256;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #(CLK_P/2) clk = ~clk;

  logic        req_valid = 1'b0, req_we = 1'b0, if_req = 1'b0;
  logic [1:0]  req_size = 2'b00;
  logic [31:0] req_addr = '0, req_wdata = '0, if_addr = '0;

  logic        be_rv, le_rv, be_iv, le_iv, be_if, le_if;
  logic [1:0]  be_rf, le_rf;
  logic [31:0] be_rd, le_rd, be_id, le_id;

  chk_mem_unit #(.MEM_BYTES(MEM_B), .BIG_END(1'b1)) u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_we(req_we),
    .req_size(req_size), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(be_rv), .rsp_fault(be_rf), .rsp_rdata(be_rd),
    .if_req(if_req), .if_addr(if_addr), .if_valid(be_iv),
    .if_fault(be_if), .if_rdata(be_id));

  chk_mem_unit #(.MEM_BYTES(MEM_B), .BIG_END(1'b0)) u_dut_le (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_we(req_we),
    .req_size(req_size), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(le_rv), .rsp_fault(le_rf), .rsp_rdata(le_rd),
    .if_req(if_req), .if_addr(if_addr), .if_valid(le_iv),
    .if_fault(le_if), .if_rdata(le_id));

  logic [7:0] mdl_be [MEM_B];
  logic [7:0] mdl_le [MEM_B];
  int  checks = 0;
  int  errors = 0;
  bit  done   = 1'b0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic int nbytes(input logic [1:0] sz);
    return (sz == 2'b00) ? 1 : (sz == 2'b01) ? 2 : 4;
  endfunction

  function automatic logic [1:0] efault(input logic [1:0] sz, input logic [31:0] a);
    if (a >= 32'(MEM_B))                 return 2'b01;
    if (sz[1] && a[1:0] != 2'b00)        return 2'b10;
    if (sz == 2'b01 && a[0])             return 2'b10;
    return 2'b00;
  endfunction

  function automatic logic [31:0] eread(input bit be, input logic [1:0] sz, input logic [31:0] a);
    logic [31:0] v = '0;
    int n = nbytes(sz);
    for (int j = 0; j < n; j++) begin
      int p = be ? int'(a) + n - 1 - j : int'(a) + j;
      v[8*j +: 8] = be ? mdl_be[p] : mdl_le[p];
    end
    return v;
  endfunction

  task automatic mwrite(input logic [1:0] sz, input logic [31:0] a, input logic [31:0] wd);
    int n = nbytes(sz);
    for (int j = 0; j < n; j++) begin
      mdl_be[int'(a) + n - 1 - j] = wd[8*j +: 8];
      mdl_le[int'(a) + j]         = wd[8*j +: 8];
    end
  endtask

  // Drive at a falling edge; the response is checked at the next falling edge.
  task automatic op(input bit we, input logic [1:0] sz, input logic [31:0] a,
                    input logic [31:0] wd, input bit fe, input logic [31:0] fa,
                    input string tag);
    logic [1:0]  ef  = efault(sz, a);
    logic [31:0] ebe = (!we && ef == 2'b00) ? eread(1'b1, sz, a) : 32'h0;
    logic [31:0] ele = (!we && ef == 2'b00) ? eread(1'b0, sz, a) : 32'h0;
    bit          ff  = fa >= 32'(MEM_B);
    logic [31:0] fbe = ff ? 32'h0 : eread(1'b1, 2'b10, {fa[31:2], 2'b00});
    logic [31:0] fle = ff ? 32'h0 : eread(1'b0, 2'b10, {fa[31:2], 2'b00});
    req_valid = 1'b1; req_we = we; req_size = sz; req_addr = a; req_wdata = wd;
    if_req = fe; if_addr = fa;
    @(negedge clk);
    chk({tag, " valid"}, {31'b0, be_rv & le_rv}, 32'd1);
    chk({tag, " fault be"}, {30'b0, be_rf}, {30'b0, ef});
    chk({tag, " fault le"}, {30'b0, le_rf}, {30'b0, ef});
    chk({tag, " data be"}, be_rd, ebe);
    chk({tag, " data le"}, le_rd, ele);
    if (fe) begin
      chk({tag, " R10 fetch valid/fault"}, {30'b0, be_iv & le_iv, be_if | le_if}, {30'b0, 1'b1, ff});
      chk({tag, " R10 fetch be"}, be_id, fbe);
      chk({tag, " R10 fetch le"}, le_id, fle);
    end
    if (we && ef == 2'b00) mwrite(sz, a, wd);
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7919));
    repeat (3) @(negedge clk);
    chk("R1 reset outputs be", {be_rv, be_rf, be_iv, be_if} | be_rd | be_id, 32'h0);
    chk("R1 reset outputs le", {le_rv, le_rf, le_iv, le_if} | le_rd | le_id, 32'h0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 after reset be", {be_rv, be_rf, be_iv, be_if} | be_rd | be_id, 32'h0);

    for (int w = 0; w < MEM_B / 4; w++)
      op(1'b1, 2'b10, 32'(4 * w), 32'hA5000000 ^ 32'(w * 32'h01010101), 1'b0, 0, "R2 preload");

    op(1'b1, 2'b10, 32'h0, 32'h11223344, 1'b0, 0, "R7 word store");
    op(1'b0, 2'b10, 32'h0, 0, 1'b0, 0, "R7 R8 word load");
    op(1'b0, 2'b00, 32'h0, 0, 1'b0, 0, "R7 R8 byte order lowest byte");
    op(1'b0, 2'b01, 32'h2, 0, 1'b0, 0, "R7 R8 half load");
    op(1'b1, 2'b00, 32'h1, 32'hFFFFFFAB, 1'b0, 0, "R9 byte store low bits");
    op(1'b1, 2'b01, 32'h6, 32'hDEADBEEF, 1'b0, 0, "R9 half store low bits");
    op(1'b0, 2'b10, 32'h0, 0, 1'b0, 0, "R9 neighbours intact");
    op(1'b0, 2'b10, 32'h4, 0, 1'b0, 0, "R9 neighbours intact 2");
    op(1'b0, 2'b00, 32'h1, 0, 1'b0, 0, "R9 byte zero-extended");
    op(1'b0, 2'b01, 32'h6, 0, 1'b0, 0, "R9 half zero-extended");
    op(1'b1, 2'b10, 32'h5, 32'hCAFEF00D, 1'b0, 0, "R4 misaligned word store");
    op(1'b0, 2'b10, 32'h6, 0, 1'b0, 0, "R4 misaligned word load");
    op(1'b0, 2'b10, 32'h4, 0, 1'b0, 0, "R4 memory unchanged");
    op(1'b1, 2'b01, 32'h3, 32'h1234, 1'b0, 0, "R5 odd half store");
    op(1'b0, 2'b00, 32'h3, 0, 1'b0, 0, "R5 odd byte no fault");
    op(1'b1, 2'b10, 32'(MEM_B), 32'h99999999, 1'b0, 0, "R3 store at limit");
    op(1'b0, 2'b00, 32'hFFFFFFFF, 0, 1'b0, 0, "R3 load far away");
    op(1'b0, 2'b10, 32'(MEM_B + 1), 0, 1'b0, 0, "R6 range over align");
    op(1'b0, 2'b01, 32'(MEM_B + 3), 0, 1'b0, 0, "R6 half range over align");
    op(1'b0, 2'b10, 32'(MEM_B - 4), 0, 1'b0, 0, "R3 last word ok");
    op(1'b0, 2'b11, 32'h0, 0, 1'b0, 0, "R2 reserved size as word");
    op(1'b0, 2'b11, 32'h2, 0, 1'b0, 0, "R2 reserved size misaligned");
    op(1'b0, 2'b00, 32'h0, 0, 1'b1, 32'h3, "R10 fetch low bits ignored");
    op(1'b0, 2'b00, 32'h0, 0, 1'b1, 32'(MEM_B), "R10 fetch range");

    for (int i = 0; i < 600; i++) begin
      logic [31:0] a  = ($urandom_range(0, 15) == 0) ? $urandom : 32'($urandom_range(0, MEM_B + 7));
      logic [31:0] fa = 32'($urandom_range(0, MEM_B + 7));
      op(1'($urandom_range(0, 1)), 2'($urandom_range(0, 3)), a, $urandom,
         1'($urandom_range(0, 1)), fa, "R3 R4 R5 random");
    end

    for (int w = 0; w < MEM_B / 4; w++)
      op(1'b0, 2'b10, 32'(4 * w), 0, 1'b1, 32'(4 * w + (w % 4)), "R10 final sweep");

    req_valid = 1'b0; if_req = 1'b0;
    @(negedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule